// File: doc/BRIEF.md
# SCSI Control-Line Register Block

This block sits between a processor bus and the control lines of a SCSI bus. Software reaches it through a small register window: an address, a write-data byte, a write strobe and a read strobe. Four storage registers hold an outgoing data byte, an initiator command, a mode byte and a target command. From these the block computes, combinationally, which of the nine control lines it pulls on the bus. The lines are RST, BSY, SEL, ATN, ACK, REQ, MSG, C/D and I/O, and each is modelled as an active-high output enable.

A mode bit picks the role. As a target the block signals the phase lines and REQ. As an initiator it signals ATN and ACK. Some lines belong to neither role (RST, BSY, SEL and the data-bus enable) and follow the initiator command in both roles. A second mode bit turns on a byte-handshake helper. A REQ seen on the bus marks a request as pending. A processor read of the bus-state register turns that request into a held ACK. The ACK is released when REQ goes away. A status register reports the pending request, a phase-match flag and the live ATN and ACK lines.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After reset, the data, initiator command, mode and target command registers all hold 0xFF. The data register appears on `dbus_out`, and the other three read back at addresses 1, 2 and 3.
- R2: Only the low three address bits select a register, so address 0xB reaches the target command register and address 0x9 reaches the initiator command register.
- R3: Initiator command bit 7 drives RST, bit 3 drives BSY, bit 2 drives SEL and bit 0 drives `dbus_oe`, whatever the role. Bit 6 (test mode) is only stored, and the whole byte reads back at address 1.
- R4: With mode bit 6 set (target), target command bit 3 drives REQ, bit 2 drives MSG, bit 1 drives C/D and bit 0 drives I/O. ACK and ATN are not driven.
- R5: With mode bit 6 clear (initiator), ATN follows initiator command bit 1. ACK is driven when initiator command bit 4 is set, or when mode bit 1 is set and the handshake ACK flag is held. REQ, MSG, C/D and I/O are not driven.
- R6: A read at address 3 returns the last value written to the target command register, never the bus lines.
- R7: A read at address 0 returns the OR of `bus_in` and `bus_oe`, packed as bit 7 RST, bit 6 BSY, bit 5 REQ, bit 4 MSG, bit 3 C/D, bit 2 I/O, bit 1 SEL, bit 0 ACK.
- R8: A read at address 5 returns bit 6 = request pending, bit 3 = phase match, bit 1 = ATN and bit 0 = ACK, with ATN and ACK taken from the combined bus. All other bits read 0. Phase match is true when target command bits 2:0 equal the combined MSG, C/D and I/O lines. Addresses 4, 6 and 7 read 0.
- R9: Mode bit 1 activates the handshake. While it is active and no ACK flag is held, `bus_in` REQ high sets the pending request, which shows on `dma_req` one cycle later. A read at address 0 while a request is pending sets the ACK flag and clears the request at the next edge.
- R10: While the ACK flag is held and `bus_in` REQ is low, the flag clears at the next edge, and with it any pending request, so the handshake ACK drops.
- R11: While mode bit 1 is clear, the pending request and the ACK flag are cleared at the next edge.
- R12: A write at address 0 stores the data byte on `dbus_out`. Writes at addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address; only bits 2:0 decode |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; qualifies the handshake side effect |
| reg_rdata | output | 8 | Read data for the current address, combinational |
| bus_in | input | 9 | Sampled control lines, active high: 0 I/O, 1 C/D, 2 MSG, 3 REQ, 4 ACK, 5 ATN, 6 SEL, 7 BSY, 8 RST |
| bus_oe | output | 9 | Control lines this block asserts, same bit order as bus_in |
| dbus_out | output | 8 | Stored data byte |
| dbus_oe | output | 1 | Data-bus drive enable |
| dma_req | output | 1 | Handshake request pending |

## Verification
The hardest situation to reach is the held ACK produced by the handshake. It needs initiator role with the handshake mode set, then REQ on the bus for a cycle, then a bus-state read in exactly the window where the request is pending, and finally REQ removed. A directed sequence walks through these steps and then aborts a second request by clearing the mode bit. The random phase makes REQ sticky and biases the mode writes toward handshake-active initiator values, so the read-during-pending and drop-on-REQ-low orderings happen many times against a cycle model in the bench.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;
  localparam int NLINES = 9;
  localparam int L_IO  = 0;
  localparam int L_CD  = 1;
  localparam int L_MSG = 2;
  localparam int L_REQ = 3;
  localparam int L_ACK = 4;
  localparam int L_ATN = 5;
  localparam int L_SEL = 6;
  localparam int L_BSY = 7;
  localparam int L_RST = 8;

  localparam int NREG = 4;
  localparam logic [2:0] RA_DATA = 3'd0;
  localparam logic [2:0] RA_ICMD = 3'd1;
  localparam logic [2:0] RA_MODE = 3'd2;
  localparam logic [2:0] RA_TCMD = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd5;

  localparam int MODE_TGT = 6;
  localparam int MODE_DMA = 1;

  localparam int IC_RST  = 7;
  localparam int IC_ACK  = 4;
  localparam int IC_BSY  = 3;
  localparam int IC_SEL  = 2;
  localparam int IC_ATN  = 1;
  localparam int IC_DOE  = 0;
endpackage

// File: rtl/scsi_ctl_regfile.sv
module scsi_ctl_regfile #(
  parameter int DW = 8,
  parameter logic [DW-1:0] RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] icmd_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] tcmd_q
);
  import scsi_ctl_pkg::*;

  logic [NREG-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= {NREG{RST_VAL}};
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr && sel == 3'(i)) regs_q[i] <= wdata;
      end
    end
  end

  assign data_q = regs_q[RA_DATA];
  assign icmd_q = regs_q[RA_ICMD];
  assign mode_q = regs_q[RA_MODE];
  assign tcmd_q = regs_q[RA_TCMD];
endmodule

// File: rtl/scsi_ctl_linemux.sv
module scsi_ctl_linemux #(
  parameter int DW = 8,
  parameter int NL = 9
) (
  input  logic [DW-1:0] icmd,
  input  logic [DW-1:0] mode,
  input  logic [DW-1:0] tcmd,
  input  logic          dma_ack,
  input  logic [NL-1:0] bus_in,
  output logic [NL-1:0] oe,
  output logic [NL-1:0] seen,
  output logic          phase_match
);
  import scsi_ctl_pkg::*;

  logic is_target;
  assign is_target = mode[MODE_TGT];

  always_comb begin
    oe        = '0;
    oe[L_RST] = icmd[IC_RST];
    oe[L_BSY] = icmd[IC_BSY];
    oe[L_SEL] = icmd[IC_SEL];
    if (is_target) begin
      oe[L_REQ] = tcmd[3];
      oe[L_MSG] = tcmd[2];
      oe[L_CD]  = tcmd[1];
      oe[L_IO]  = tcmd[0];
    end else begin
      oe[L_ATN] = icmd[IC_ATN];
      oe[L_ACK] = icmd[IC_ACK] | (mode[MODE_DMA] & dma_ack);
    end
  end

  for (genvar g = 0; g < NL; g++) begin : g_seen
    assign seen[g] = bus_in[g] | oe[g];
  end

  assign phase_match = (tcmd[2:0] == {seen[L_MSG], seen[L_CD], seen[L_IO]});
endmodule

// File: rtl/scsi_ctl_dma.sv
module scsi_ctl_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic req_line,
  input  logic bus_read,
  output logic pend_q,
  output logic ack_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else if (!active) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else if (bus_read && pend_q) begin
      ack_q  <= 1'b1;
      pend_q <= 1'b0;
    end else if (ack_q && !req_line) begin
      ack_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (!ack_q && req_line) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs #(
  parameter int ADDR_W = 4,
  parameter int DW     = 8,
  parameter int NL     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NL-1:0]     bus_in,
  output logic [NL-1:0]     bus_oe,
  output logic [DW-1:0]     dbus_out,
  output logic              dbus_oe,
  output logic              dma_req
);
  import scsi_ctl_pkg::*;

  logic [2:0]    sel;
  logic [DW-1:0] data_q, icmd_q, mode_q, tcmd_q;
  logic [NL-1:0] seen;
  logic          pmatch, dma_pend, dma_ack;

  assign sel = reg_addr[2:0];

  scsi_ctl_regfile #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
    .data_q(data_q), .icmd_q(icmd_q), .mode_q(mode_q), .tcmd_q(tcmd_q)
  );

  scsi_ctl_linemux #(.DW(DW), .NL(NL)) u_mux (
    .icmd(icmd_q), .mode(mode_q), .tcmd(tcmd_q), .dma_ack(dma_ack),
    .bus_in(bus_in), .oe(bus_oe), .seen(seen), .phase_match(pmatch)
  );

  scsi_ctl_dma u_dma (
    .clk(clk), .rst_n(rst_n), .active(mode_q[MODE_DMA]),
    .req_line(bus_in[L_REQ]), .bus_read(reg_rd && sel == RA_DATA),
    .pend_q(dma_pend), .ack_q(dma_ack)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_DATA: reg_rdata = {seen[L_RST], seen[L_BSY], seen[L_REQ], seen[L_MSG],
                            seen[L_CD], seen[L_IO], seen[L_SEL], seen[L_ACK]};
      RA_ICMD: reg_rdata = icmd_q;
      RA_MODE: reg_rdata = mode_q;
      RA_TCMD: reg_rdata = tcmd_q;
      RA_STAT: begin
        reg_rdata[6] = dma_pend;
        reg_rdata[3] = pmatch;
        reg_rdata[1] = seen[L_ATN];
        reg_rdata[0] = seen[L_ACK];
      end
      default: reg_rdata = '0;
    endcase
  end

  assign dbus_out = data_q;
  assign dbus_oe  = icmd_q[IC_DOE];
  assign dma_req  = dma_pend;
endmodule

// File: rtl/scsi_ctl_chk.sv
module scsi_ctl_chk #(
  parameter int DW = 8,
  parameter int NL = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] mode,
  input logic [NL-1:0] oe,
  input logic [NL-1:0] bus_in,
  input logic          rd,
  input logic [2:0]    sel,
  input logic          pend,
  input logic          ack_flag
);
  import scsi_ctl_pkg::*;

  AST_TGT_QUIET_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode[MODE_TGT] |-> !oe[L_ACK] && !oe[L_ATN]); // R4

  AST_INIT_QUIET_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[MODE_TGT] |-> !oe[L_REQ] && !oe[L_MSG] && !oe[L_CD] && !oe[L_IO]); // R5

  AST_READ_TAKES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mode[MODE_DMA] && rd && sel == 3'd0 && pend |=> ack_flag && !pend); // R9

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mode[MODE_DMA] && ack_flag && !bus_in[L_REQ] |=> !ack_flag); // R10

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[MODE_DMA] |=> !pend && !ack_flag); // R11
endmodule

bind scsi_ctl_regs scsi_ctl_chk #(.DW(DW), .NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .oe(bus_oe), .bus_in(bus_in),
  .rd(reg_rd), .sel(reg_addr[2:0]), .pend(dma_pend), .ack_flag(dma_ack)
);

// File: tb/tb_scsi_ctl_regs.sv
module tb_scsi_ctl_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_rdata;
  logic [8:0] bus_in, bus_oe;
  logic [7:0] dbus_out;
  logic       dbus_oe, dma_req;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] m_data, m_icmd, m_mode, m_tcmd;
  logic       m_pend, m_flag;
  logic [8:0] m_bin;

  always #10 clk = ~clk;

  scsi_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .bus_in(bus_in),
    .bus_oe(bus_oe), .dbus_out(dbus_out), .dbus_oe(dbus_oe), .dma_req(dma_req)
  );

  function automatic logic [8:0] exp_oe();
    logic [8:0] o = '0;
    o[8] = m_icmd[7]; o[7] = m_icmd[3]; o[6] = m_icmd[2];
    if (m_mode[6]) begin
      o[3] = m_tcmd[3]; o[2] = m_tcmd[2]; o[1] = m_tcmd[1]; o[0] = m_tcmd[0];
    end else begin
      o[5] = m_icmd[1];
      o[4] = m_icmd[4] | (m_mode[1] & m_flag);
    end
    return o;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    logic [8:0] c = m_bin | exp_oe();
    logic [7:0] r = '0;
    case (a)
      3'd0: r = {c[8], c[7], c[3], c[2], c[1], c[0], c[6], c[4]};
      3'd1: r = m_icmd;
      3'd2: r = m_mode;
      3'd3: r = m_tcmd;
      3'd5: begin
        r[6] = m_pend;
        r[3] = (m_tcmd[2:0] == {c[2], c[1], c[0]});
        r[1] = c[5];
        r[0] = c[4];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R3";
      3'd2: return "R1";
      3'd3: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic cyc(input bit wr, input bit rd, input logic [3:0] a,
                     input logic [7:0] d, input logic [8:0] bin);
    logic [2:0] s = a[2:0];
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; bus_in = bin; m_bin = bin;
    #2;
    if (rd) check(rd_tag(s), 16'(reg_rdata), 16'(exp_rd(s)));
    @(posedge clk);
    if (!m_mode[1]) begin
      m_pend = 1'b0; m_flag = 1'b0;
    end else if (rd && s == 3'd0 && m_pend) begin
      m_flag = 1'b1; m_pend = 1'b0;
    end else if (m_flag && !bin[3]) begin
      m_flag = 1'b0; m_pend = 1'b0;
    end else if (!m_flag && bin[3]) begin
      m_pend = 1'b1;
    end
    if (wr) begin
      case (s)
        3'd0: m_data = d;
        3'd1: m_icmd = d;
        3'd2: m_mode = d;
        3'd3: m_tcmd = d;
        default: ;
      endcase
    end
    #2;
    check("R4 R5", 16'(bus_oe), 16'(exp_oe()));
    check("R9", 16'(dma_req), 16'(m_pend));
    check("R12", 16'(dbus_out), 16'(m_data));
    check("R3", 16'(dbus_oe), 16'(m_icmd[0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5C51));
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; bus_in = 0;
    m_data = 8'hFF; m_icmd = 8'hFF; m_mode = 8'hFF; m_tcmd = 8'hFF;
    m_pend = 0; m_flag = 0; m_bin = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1", 16'(dbus_out), 16'hFF);
    cyc(0, 1, 4'd1, 0, 0); check("R1", 16'(m_icmd), 16'hFF);
    cyc(0, 1, 4'd2, 0, 0);
    cyc(0, 1, 4'd3, 0, 0);

    // R2 aliasing
    cyc(1, 0, 4'hB, 8'h5A, 0);
    cyc(0, 1, 4'd3, 0, 0); check("R2", 16'(reg_rdata), 16'h5A);
    cyc(1, 0, 4'h9, 8'h41, 0);
    cyc(0, 1, 4'd1, 0, 0); check("R2", 16'(reg_rdata), 16'h41);

    // R12 ignored writes
    cyc(1, 0, 4'd6, 8'h00, 0);
    cyc(1, 0, 4'd4, 8'h00, 0);
    cyc(0, 1, 4'd2, 0, 0); check("R12", 16'(reg_rdata), 16'hFF);
    cyc(0, 1, 4'd6, 0, 0); check("R8", 16'(reg_rdata), 16'h00);

    // R5 initiator lines
    cyc(1, 0, 4'd2, 8'h00, 0);
    cyc(1, 0, 4'd1, 8'h12, 0);
    check("R5", 16'(bus_oe), 16'h030);
    cyc(0, 1, 4'd5, 0, 0); check("R8", 16'(reg_rdata), 16'h03);

    // R8 phase match in initiator role
    cyc(1, 0, 4'd3, 8'h05, 0);
    cyc(0, 1, 4'd5, 0, 9'h005); check("R8", 16'(reg_rdata[3]), 16'h1);
    cyc(0, 1, 4'd5, 0, 9'h004); check("R8", 16'(reg_rdata[3]), 16'h0);

    // R9 R10 handshake
    cyc(1, 0, 4'd1, 8'h00, 0);
    cyc(1, 0, 4'd2, 8'h02, 0);
    cyc(0, 0, 4'd0, 0, 9'h008); check("R9", 16'(dma_req), 16'h1);
    cyc(0, 1, 4'd0, 0, 9'h008); check("R9", 16'(bus_oe[4]), 16'h1);
    check("R9", 16'(dma_req), 16'h0);
    cyc(0, 0, 4'd0, 0, 9'h008); check("R10", 16'(bus_oe[4]), 16'h1);
    cyc(0, 0, 4'd0, 0, 9'h000); check("R10", 16'(bus_oe[4]), 16'h0);

    // R11 abort
    cyc(0, 0, 4'd0, 0, 9'h008); check("R11", 16'(dma_req), 16'h1);
    cyc(1, 0, 4'd2, 8'h00, 9'h008);
    cyc(0, 0, 4'd0, 0, 9'h008); check("R11", 16'(dma_req), 16'h0);

    // R4 target role
    cyc(1, 0, 4'd2, 8'h40, 0);
    cyc(1, 0, 4'd3, 8'h0A, 0);
    check("R4", 16'(bus_oe), 16'h00A);
    cyc(0, 1, 4'd3, 0, 9'h1FF); check("R6", 16'(reg_rdata), 16'h0A);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      logic [3:0] a = 4'($urandom_range(0, 15));
      logic [7:0] d = 8'($urandom);
      logic [8:0] b = 9'($urandom) & 9'h1F7;
      if ($urandom_range(0, 3) != 0) b[3] = m_bin[3]; else b[3] = ~m_bin[3];
      if (a[2:0] == 3'd2 && $urandom_range(0, 1) == 1) d = d & 8'hBF | 8'h02;
      if (op < 3) cyc(1, 0, a, d, b);
      else if (op < 6) cyc(0, 1, 4'($urandom_range(0, 1) ? 0 : a), 0, b);
      else cyc(0, 0, a, 0, b);
    end

    @(negedge clk); reg_wr = 0; reg_rd = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule